// File: doc/BRIEF.md
# Virtual Function Routing ID Decoder

This block takes an 8-bit device/function number (routing ID) seen on the physical function's own bus. It decides whether that number addresses the physical function (PF), one of its virtual functions (VFs), or nothing. The VF layout comes from four values in the capability register block: the VF offset, the VF stride, the total and active VF counts. Two control bits also take part: VF enable and alternative routing ID interpretation (ARI) mode. The VF stride is restricted to powers of two and is supplied as its base-2 logarithm, so the division that recovers the VF index becomes a shift and a mask.

The decoder also reports a static configuration-error flag when the VF numbering cannot fit. This happens when the last VF would run past routing ID 255, or, outside ARI mode, when it would leave the PF's device number. While the flag is set, no VF decodes. An identification word is returned alongside the decode: a VF answers all ones, and the PF answers its own identification value.

All decode logic is combinational. A single register stage holds every result, so each output is valid exactly one clock after its inputs.

Top module: `vf_rid_decoder`

## Requirements
- R1: When `req_rid_i` equals `pf_rid_i`, the result is `hit_o`=1, `vf_sel_o`=0 and `vf_idx_o`=0, whatever the VF settings are, including an offset of zero.
- R2: The routing ID of VF k is `pf_rid_i + vf_ofs_i + k * 2^stride_log_i`. A request that matches it gives `hit_o`=1, `vf_sel_o`=1 and `vf_idx_o`=k.
- R3: A request below the first VF routing ID, or one that falls between two VF routing IDs, gives `hit_o`=0, unless R1 applies.
- R4: Only VF indices below `num_vfs_i` decode. If `num_vfs_i` exceeds `total_vfs_i`, no VF decodes.
- R5: With `vf_en_i`=0, no VF decodes.
- R6: Let last = `pf_rid_i + vf_ofs_i + (total_vfs_i - 1) * 2^stride_log_i`. When `total_vfs_i` is non-zero and last is above 255, `cfg_err_o`=1. When `total_vfs_i` is zero, `cfg_err_o`=0.
- R7: When `ari_i`=0, `total_vfs_i` is non-zero and bits [7:3] of last differ from bits [7:3] of `pf_rid_i`, `cfg_err_o`=1. While `cfg_err_o`=1, no VF decodes.
- R8: `ident_o` is 16'hFFFF on a VF hit, `pf_ident_i` on a PF hit, and 0 on a miss.
- R9: Every output is registered and reflects the inputs present at the previous rising clock edge. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the output register |
| pf_rid_i | input | 8 | Routing ID of the physical function |
| vf_ofs_i | input | 8 | Distance from the PF routing ID to the first VF |
| stride_log_i | input | 3 | Base-2 logarithm of the VF stride |
| total_vfs_i | input | 8 | Number of VFs the layout must accommodate |
| num_vfs_i | input | 8 | Number of VFs currently active |
| vf_en_i | input | 1 | VF enable |
| ari_i | input | 1 | ARI mode: VFs may leave the PF's device number |
| pf_ident_i | input | 16 | Identification word returned for the PF |
| req_rid_i | input | 8 | Routing ID to decode |
| hit_o | output | 1 | Request addresses the PF or an active VF |
| vf_sel_o | output | 1 | 1 when the hit is a VF, 0 for the PF |
| vf_idx_o | output | 8 | Zero-based VF index on a VF hit |
| cfg_err_o | output | 1 | VF layout does not fit |
| ident_o | output | 16 | Identification word for the addressed function |

## Verification
Every result, including the configuration-error flag, is due one rising edge after the inputs that produce it. The bench drives new inputs 1 ns after an edge and samples 1 ns after the following edge. It also confirms that a changed request has not yet reached the outputs before that edge. The sweeps cover all 256 request values for each of several layouts, and expected results come from an arithmetic walk over the VF indices.

// File: rtl/vf_rid_pkg.sv
`timescale 1ns/1ps
package vf_rid_pkg;

    // Number of low routing-ID bits that hold the function number.
    localparam int FN_BITS = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PF   = 2'd1,
        SEL_VF   = 2'd2
    } sel_e;

endpackage

// File: rtl/vf_rid_layout.sv
`timescale 1ns/1ps
// Works out where the VF block starts and whether it fits on the bus.
module vf_rid_layout #(
    parameter int RID_W  = 8,
    parameter int CNT_W  = 8,
    parameter int SLOG_W = 3,
    parameter int EXT_W  = 17
) (
    input  logic [RID_W-1:0]  pf_rid_i,
    input  logic [RID_W-1:0]  vf_ofs_i,
    input  logic [SLOG_W-1:0] stride_log_i,
    input  logic [CNT_W-1:0]  total_vfs_i,
    input  logic              ari_i,
    output logic [EXT_W-1:0]  first_o,
    output logic              cfg_err_o
);
    import vf_rid_pkg::*;

    localparam logic [EXT_W-1:0] RID_MAX = EXT_W'((1 << RID_W) - 1);

    logic [EXT_W-1:0] span;
    logic [EXT_W-1:0] last;
    logic             over_top;
    logic             dev_moved;

    always_comb begin
        first_o = EXT_W'(pf_rid_i) + EXT_W'(vf_ofs_i);
        if (total_vfs_i == '0) begin
            span = '0;
        end else begin
            span = (EXT_W'(total_vfs_i) - EXT_W'(1)) << stride_log_i;
        end
        last      = first_o + span;
        over_top  = last > RID_MAX;
        dev_moved = last[RID_W-1:FN_BITS] != pf_rid_i[RID_W-1:FN_BITS];
        cfg_err_o = (total_vfs_i != '0) && (over_top || (!ari_i && dev_moved));
    end

endmodule

// File: rtl/vf_rid_match.sv
`timescale 1ns/1ps
// Offset/stride arithmetic: turns a routing ID into a VF index.
module vf_rid_match #(
    parameter int RID_W  = 8,
    parameter int CNT_W  = 8,
    parameter int SLOG_W = 3,
    parameter int EXT_W  = 17
) (
    input  logic [RID_W-1:0]  req_rid_i,
    input  logic [EXT_W-1:0]  first_i,
    input  logic [SLOG_W-1:0] stride_log_i,
    input  logic [CNT_W-1:0]  total_vfs_i,
    input  logic [CNT_W-1:0]  num_vfs_i,
    input  logic              vf_en_i,
    input  logic              cfg_err_i,
    output logic              vf_hit_o,
    output logic [CNT_W-1:0]  vf_idx_o
);
    logic [EXT_W-1:0] req_ext;
    logic [EXT_W-1:0] diff;
    logic [EXT_W-1:0] step_mask;
    logic [EXT_W-1:0] quot;
    logic             ahead;
    logic             aligned;
    logic             in_range;
    logic             count_ok;

    always_comb begin
        req_ext   = EXT_W'(req_rid_i);
        ahead     = req_ext >= first_i;
        diff      = req_ext - first_i;
        step_mask = (EXT_W'(1) << stride_log_i) - EXT_W'(1);
        aligned   = (diff & step_mask) == '0;
        quot      = diff >> stride_log_i;
        in_range  = quot < EXT_W'(num_vfs_i);
        count_ok  = num_vfs_i <= total_vfs_i;
        vf_hit_o  = vf_en_i && !cfg_err_i && ahead && aligned && in_range && count_ok;
        vf_idx_o  = quot[CNT_W-1:0];
    end

endmodule

// File: rtl/vf_rid_decoder.sv
`timescale 1ns/1ps
module vf_rid_decoder #(
    parameter int RID_W  = 8,
    parameter int CNT_W  = 8,
    parameter int SLOG_W = 3,
    parameter int ID_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RID_W-1:0]  pf_rid_i,
    input  logic [RID_W-1:0]  vf_ofs_i,
    input  logic [SLOG_W-1:0] stride_log_i,
    input  logic [CNT_W-1:0]  total_vfs_i,
    input  logic [CNT_W-1:0]  num_vfs_i,
    input  logic              vf_en_i,
    input  logic              ari_i,
    input  logic [ID_W-1:0]   pf_ident_i,
    input  logic [RID_W-1:0]  req_rid_i,
    output logic              hit_o,
    output logic              vf_sel_o,
    output logic [CNT_W-1:0]  vf_idx_o,
    output logic              cfg_err_o,
    output logic [ID_W-1:0]   ident_o
);
    import vf_rid_pkg::*;

    // Wide enough for first VF plus the largest shifted span.
    localparam int EXT_W = CNT_W + (1 << SLOG_W) + 1;
    localparam logic [ID_W-1:0] VF_IDENT = {ID_W{1'b1}};

    typedef struct packed {
        logic             hit;
        sel_e             sel;
        logic [CNT_W-1:0] idx;
        logic             cfg_err;
        logic [ID_W-1:0]  ident;
    } dec_t;

    logic [EXT_W-1:0] first_vf;
    logic             lay_err;
    logic             vf_hit;
    logic [CNT_W-1:0] vf_idx;
    dec_t             dec_d;
    dec_t             dec_q;

    vf_rid_layout #(
        .RID_W (RID_W),
        .CNT_W (CNT_W),
        .SLOG_W(SLOG_W),
        .EXT_W (EXT_W)
    ) i_layout (
        .pf_rid_i    (pf_rid_i),
        .vf_ofs_i    (vf_ofs_i),
        .stride_log_i(stride_log_i),
        .total_vfs_i (total_vfs_i),
        .ari_i       (ari_i),
        .first_o     (first_vf),
        .cfg_err_o   (lay_err)
    );

    vf_rid_match #(
        .RID_W (RID_W),
        .CNT_W (CNT_W),
        .SLOG_W(SLOG_W),
        .EXT_W (EXT_W)
    ) i_match (
        .req_rid_i   (req_rid_i),
        .first_i     (first_vf),
        .stride_log_i(stride_log_i),
        .total_vfs_i (total_vfs_i),
        .num_vfs_i   (num_vfs_i),
        .vf_en_i     (vf_en_i),
        .cfg_err_i   (lay_err),
        .vf_hit_o    (vf_hit),
        .vf_idx_o    (vf_idx)
    );

    always_comb begin
        dec_d         = '0;
        dec_d.sel     = SEL_NONE;
        dec_d.cfg_err = lay_err;
        if (req_rid_i == pf_rid_i) begin
            // PF routing ID takes precedence over any VF interpretation.
            dec_d.hit   = 1'b1;
            dec_d.sel   = SEL_PF;
            dec_d.ident = pf_ident_i;
        end else if (vf_hit) begin
            dec_d.hit   = 1'b1;
            dec_d.sel   = SEL_VF;
            dec_d.idx   = vf_idx;
            dec_d.ident = VF_IDENT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign hit_o     = dec_q.hit;
    assign vf_sel_o  = dec_q.sel == SEL_VF;
    assign vf_idx_o  = dec_q.idx;
    assign cfg_err_o = dec_q.cfg_err;
    assign ident_o   = dec_q.ident;

    AST_PF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rid_i == pf_rid_i) |=> (hit_o && !vf_sel_o && vf_idx_o == '0)); // R1
    AST_IDX_BELOW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        vf_sel_o |-> (vf_idx_o < $past(num_vfs_i))); // R4
    AST_DISABLED_NO_VF: assert property (@(posedge clk) disable iff (!rst_n)
        !vf_en_i |=> !vf_sel_o); // R5
    AST_EMPTY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (total_vfs_i == '0) |=> !cfg_err_o); // R6
    AST_ERR_BLOCKS_VF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !vf_sel_o); // R7
    AST_VF_IDENT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        vf_sel_o |-> (hit_o && ident_o == VF_IDENT)); // R8
    AST_MISS_IDENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (ident_o == '0 && !vf_sel_o)); // R8

endmodule

// File: tb/test_vf_rid_decoder.sv
`timescale 1ns/1ps
module test_vf_rid_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pf_rid = '0;
    logic [7:0]  vf_ofs = '0;
    logic [2:0]  stride_log = '0;
    logic [7:0]  total_vfs = '0;
    logic [7:0]  num_vfs = '0;
    logic        vf_en = 1'b0;
    logic        ari = 1'b0;
    logic [15:0] pf_ident = '0;
    logic [7:0]  req_rid = '0;
    logic        hit, vf_sel, cfg_err;
    logic [7:0]  vf_idx;
    logic [15:0] ident;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vf_rid_decoder i_vf_rid_decoder (
        .clk(clk), .rst_n(rst_n), .pf_rid_i(pf_rid), .vf_ofs_i(vf_ofs),
        .stride_log_i(stride_log), .total_vfs_i(total_vfs), .num_vfs_i(num_vfs),
        .vf_en_i(vf_en), .ari_i(ari), .pf_ident_i(pf_ident), .req_rid_i(req_rid),
        .hit_o(hit), .vf_sel_o(vf_sel), .vf_idx_o(vf_idx), .cfg_err_o(cfg_err),
        .ident_o(ident)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pack_out(bit h, bit v, int idx, bit e, int id);
        return (int'(h) << 26) | (int'(v) << 25) | ((idx & 8'hFF) << 17)
             | (int'(e) << 16) | (id & 16'hFFFF);
    endfunction

    // Expected outputs by walking every active VF routing ID.
    task automatic model(input int r, output int exp_pk, output string tag);
        int  first, stride, last, idx;
        bit  err, big, pfh, vf;
        first  = int'(pf_rid) + int'(vf_ofs);
        stride = 1 << stride_log;
        last   = first + stride * (int'(total_vfs) - 1);
        big    = (total_vfs != 0) && (last > 255);
        err    = (total_vfs != 0) && (big || (!ari && ((last >> 3) != (int'(pf_rid) >> 3))));
        pfh    = (r == int'(pf_rid));
        vf     = 1'b0;
        idx    = 0;
        if (!pfh && vf_en && !err && num_vfs <= total_vfs) begin
            for (int k = 0; k < int'(num_vfs); k++) begin
                if (first + k * stride == r) begin
                    vf  = 1'b1;
                    idx = k;
                end
            end
        end
        exp_pk = pack_out(pfh | vf, vf, idx, err,
                          pfh ? int'(pf_ident) : (vf ? 16'hFFFF : 0));
        if (pfh)                          tag = "R1";
        else if (big)                     tag = "R6";
        else if (err)                     tag = "R7";
        else if (!vf_en)                  tag = "R5";
        else if (num_vfs > total_vfs)     tag = "R4";
        else if (vf)                      tag = "R2/R8";
        else                              tag = "R3";
    endtask

    task automatic sweep(input int p, input int o, input int s, input int t,
                         input int n, input bit en, input bit a, input int pid);
        int    exp_pk;
        string tag;
        pf_rid = 8'(p); vf_ofs = 8'(o); stride_log = 3'(s);
        total_vfs = 8'(t); num_vfs = 8'(n); vf_en = en; ari = a;
        pf_ident = 16'(pid);
        for (int r = 0; r < 256; r++) begin
            req_rid = 8'(r);
            @(posedge clk);
            #1;
            model(r, exp_pk, tag);
            check(pack_out(hit, vf_sel, int'(vf_idx), cfg_err, int'(ident)) == exp_pk,
                  tag, $sformatf("req=%0h {hit,vf,idx,err,ident}", r),
                  pack_out(hit, vf_sel, int'(vf_idx), cfg_err, int'(ident)), exp_pk);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset holds every output at 0 even with a PF match present.
        pf_rid = 8'h10; req_rid = 8'h10; pf_ident = 16'h1234;
        repeat (3) @(posedge clk);
        #1;
        check(pack_out(hit, vf_sel, int'(vf_idx), cfg_err, int'(ident)) == 0,
              "R9", "outputs in reset", pack_out(hit, vf_sel, int'(vf_idx), cfg_err, int'(ident)), 0);
        rst_n = 1'b1;

        sweep(8'h10, 1, 0, 7, 7, 1, 0, 16'hA5A5);    // R2 unit stride, fits device
        sweep(8'h00, 4, 2, 16, 10, 1, 1, 16'h1111);  // R2 R4 stride 4, partial enable
        sweep(8'h00, 4, 2, 16, 10, 0, 1, 16'h1111);  // R5 disabled
        sweep(8'h20, 2, 0, 8, 3, 1, 0, 16'h2222);    // R7 leaves device number
        sweep(8'h20, 2, 0, 8, 3, 1, 1, 16'h2222);    // R7 same layout legal in ARI
        sweep(8'hF0, 8'h10, 0, 1, 1, 1, 1, 16'h3333); // R6 first VF past 255
        sweep(8'h80, 8'h40, 3, 8, 8, 1, 1, 16'h4444); // R2 last VF at 0xF8
        sweep(8'h80, 8'h40, 3, 9, 8, 1, 1, 16'h4444); // R6 one more VF overflows
        sweep(8'h00, 1, 0, 4, 5, 1, 1, 16'h5555);    // R4 active above total
        sweep(8'h30, 0, 1, 4, 4, 1, 1, 16'h6666);    // R1 zero offset, PF wins
        sweep(8'h40, 3, 7, 2, 2, 1, 1, 16'h7777);    // R3 widest stride
        sweep(8'h50, 9, 0, 0, 0, 1, 0, 16'h8888);    // R6 no VFs, no error

        // R9: output changes only at the next rising edge.
        pf_rid = 8'h10; vf_ofs = 8'd1; stride_log = 3'd0; total_vfs = 8'd7;
        num_vfs = 8'd7; vf_en = 1'b1; ari = 1'b0; pf_ident = 16'hBEEF;
        req_rid = 8'hEE;
        @(posedge clk);
        #1;
        check(hit == 1'b0, "R9", "miss registered", int'(hit), 0);
        req_rid = 8'h13;
        #1;
        check(hit == 1'b0, "R9", "no change before edge", int'(hit), 0);
        @(posedge clk);
        #1;
        check(hit && vf_sel && vf_idx == 8'd2, "R9", "VF 2 after edge",
              int'({hit, vf_sel, vf_idx}), int'({1'b1, 1'b1, 8'd2}));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule